// File: doc/BRIEF.md
# External Bus Controller with Hold and DMA

This block sits between a 16-bit processor core and the pins of its external memory and I/O bus. The core hands it one access at a time (address, write flag, target space, write data). The block runs a bus cycle of at least two clocks. It drives one active-low select for the data, program or I/O space, a strobe, a read select that can feed a memory output enable, and a direction line. It stretches the cycle for as long as the external READY input is sampled low. Read data returns to the core with a one-clock valid pulse.

Every pin is modelled as a separate output, output enable and input, so the chip level can build the pads. An active-low OFF input releases every output the block drives. A hold request is taken only at a cycle boundary. While hold is acknowledged, the address, strobe and direction pins act as inputs. With bus request held low, an external master can then read and write a small on-chip single-access RAM.

Top module: `xbus_ctrl`

## Requirements
- R1: During an access, exactly one of `ds_n`, `ps_n` and `is_n` is low, chosen by `req_space` (0 selects data, 1 selects program, 2 and 3 select I/O), and `addr_o` carries the accepted address. Outside an access all three selects are high.
- R2: `req_ack` is high in a clock when `req_valid` is high, the block is idle, `hold_n` is high and reset is released. The clock after acceptance is a setup clock with the selects low and `strb_o` high. `strb_o` then goes low and stays low until READY is sampled high at a rising edge, so each low sample adds one clock.
- R3: `rw_o` is high except from the setup clock through the completing clock of a write access, when it is low.
- R4: `rd_n` is low from the setup clock through the completing clock of every read access, whatever its space, and high otherwise.
- R5: On a read, `data_i` is captured at the rising edge where the strobe completes. `rsp_valid` is then high for exactly the next clock, with that word on `rsp_rdata`.
- R6: While `off_n` is low, `pin_oe` and `data_oe` are both low. `pin_oe` enables address, selects, strobe, read select and direction.
- R7: `data_oe` is high only during a write access while `hold_n` is high and reset is released, or during a DMA read (R10). In the write case `data_o` carries the accepted write data.
- R8: A low `hold_n` seen while idle, or at the edge that completes a cycle, moves the block into hold, and `holda_n` goes low one clock later. In hold, `pin_oe` is low and no request is accepted. `holda_n` returns high one clock after `hold_n` is sampled high.
- R9: In hold with `br_n` low, address, data and direction are captured at every edge where `strb_i` is low. At the first edge where `strb_i` is high again, the captured word is written to the RAM if the captured direction was low (write) and the captured address is below the RAM depth (256 words by default). Other addresses are ignored.
- R10: In hold with `br_n` low, `strb_i` low, `rw_i` high and `addr_i` below the RAM depth, `data_oe` is high and `data_o` shows the RAM word at `addr_i`, with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_n | input | 1 | Active-low: release all driven pins |
| hold_n | input | 1 | Active-low hold request |
| br_n | input | 1 | Active-low external bus request (enables DMA in hold) |
| ready | input | 1 | External ready; low stretches the strobe |
| req_valid | input | 1 | Core access request |
| req_we | input | 1 | Core access is a write |
| req_space | input | 2 | Target space: 0 data, 1 program, 2 or 3 I/O |
| req_addr | input | AW | Core access address |
| req_wdata | input | DW | Core write data |
| req_ack | output | 1 | Request accepted this clock |
| rsp_valid | output | 1 | One-clock read data valid |
| rsp_rdata | output | DW | Read data to the core |
| holda_n | output | 1 | Active-low hold acknowledge |
| pin_oe | output | 1 | Enable for address, selects, strobe, read select, direction |
| addr_o | output | AW | Address pins, driven value |
| addr_i | input | AW | Address pins, received value (DMA) |
| data_oe | output | 1 | Data pin enable |
| data_o | output | DW | Data pins, driven value |
| data_i | input | DW | Data pins, received value |
| ds_n | output | 1 | Data space select |
| ps_n | output | 1 | Program space select |
| is_n | output | 1 | I/O space select |
| strb_o | output | 1 | Strobe, driven value |
| strb_i | input | 1 | Strobe, received value (DMA) |
| rd_n | output | 1 | Read select |
| rw_o | output | 1 | Direction, driven value (high = read) |
| rw_i | input | 1 | Direction, received value (DMA) |

## Verification
The bench targets reads with several wait states. A block that sampled READY once would drop the strobe early and return the wrong word. Hold is raised in the middle of a stretched write: a block that granted hold at once would acknowledge while the strobe is still low, and one that ignored the hold request for data would keep driving the data bus. DMA writes go to addresses just outside the RAM window. A block without the window check would alias them onto low words, and a later read of such a word would show the wrong value. A request held high during hold must not be accepted until the clock after release, and a block that released on the same edge would start a cycle one clock early.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_STRB  = 2'd2,
      PH_HOLD  = 2'd3
   } xbus_ph_e;

   typedef enum logic [1:0] {
      SP_DATA   = 2'd0,
      SP_PROG   = 2'd1,
      SP_IO     = 2'd2,
      SP_IO_ALT = 2'd3
   } xbus_sp_e;

   typedef struct packed {
      logic ds_n;
      logic ps_n;
      logic is_n;
   } xbus_sel_t;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_n,
   input  logic          ready,
   input  logic          req_valid,
   input  logic          req_we,
   input  logic [1:0]    req_space,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] data_i,
   output xbus_ph_e      phase,
   output logic          req_ack,
   output logic          cyc_we,
   output logic [1:0]    cyc_space,
   output logic [AW-1:0] cyc_addr,
   output logic [DW-1:0] cyc_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   xbus_ph_e ph_d;
   logic     done;

   assign req_ack = rst_n && (phase == PH_IDLE) && hold_n && req_valid;
   assign done    = (phase == PH_STRB) && ready;

   always_comb begin
      ph_d = phase;
      case (phase)
         PH_IDLE:  if (!hold_n) ph_d = PH_HOLD;
                   else if (req_valid) ph_d = PH_SETUP;
         PH_SETUP: ph_d = PH_STRB;
         PH_STRB:  if (ready) ph_d = hold_n ? PH_IDLE : PH_HOLD;
         PH_HOLD:  if (hold_n) ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cyc_we    <= 1'b0;
         cyc_space <= '0;
         cyc_addr  <= '0;
         cyc_wdata <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         phase     <= ph_d;
         rsp_valid <= done && !cyc_we;
         if (req_ack) begin
            cyc_we    <= req_we;
            cyc_space <= req_space;
            cyc_addr  <= req_addr;
            cyc_wdata <= req_wdata;
         end
         if (done && !cyc_we) rsp_rdata <= data_i;
      end
   end

endmodule

// File: rtl/xbus_sel_dec.sv
module xbus_sel_dec
   import xbus_pkg::*;
(
   input  logic       active,
   input  logic [1:0] space,
   output xbus_sel_t  sel
);

   always_comb begin
      sel = '{ds_n: 1'b1, ps_n: 1'b1, is_n: 1'b1};
      if (active) begin
         case (xbus_sp_e'(space))
            SP_DATA: sel.ds_n = 1'b0;
            SP_PROG: sel.ps_n = 1'b0;
            default: sel.is_n = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/xbus_dma_ram.sv
module xbus_dma_ram #(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int DEPTH = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dma_act,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          strb_i,
   input  logic          rw_i,
   output logic          rd_drive,
   output logic [DW-1:0] rd_data
);

   localparam int RAW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("xbus_dma_ram: DEPTH must be a power of two");
      assert (RAW <= AW)
         else $error("xbus_dma_ram: DEPTH exceeds address space");
   end

   logic [DW-1:0]  mem [DEPTH];
   logic           hit;
   logic           strb_q;
   logic           l_rw;
   logic           l_hit;
   logic [RAW-1:0] l_addr;
   logic [DW-1:0]  l_data;

   generate
      if (RAW < AW) begin : g_window
         assign hit = (addr_i[AW-1:RAW] == '0);
      end else begin : g_full
         assign hit = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b1;
         l_rw   <= 1'b1;
         l_hit  <= 1'b0;
         l_addr <= '0;
         l_data <= '0;
      end else begin
         strb_q <= strb_i;
         if (dma_act && !strb_i) begin
            l_rw   <= rw_i;
            l_hit  <= hit;
            l_addr <= addr_i[RAW-1:0];
            l_data <= data_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (dma_act && strb_i && !strb_q && !l_rw && l_hit)
         mem[l_addr] <= l_data;
   end

   assign rd_drive = dma_act && !strb_i && rw_i && hit;
   assign rd_data  = mem[addr_i[RAW-1:0]];

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int RAM_DEPTH = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          off_n,
   input  logic          hold_n,
   input  logic          br_n,
   input  logic          ready,
   input  logic          req_valid,
   input  logic          req_we,
   input  logic [1:0]    req_space,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ack,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          holda_n,
   output logic          pin_oe,
   output logic [AW-1:0] addr_o,
   input  logic [AW-1:0] addr_i,
   output logic          data_oe,
   output logic [DW-1:0] data_o,
   input  logic [DW-1:0] data_i,
   output logic          ds_n,
   output logic          ps_n,
   output logic          is_n,
   output logic          strb_o,
   input  logic          strb_i,
   output logic          rd_n,
   output logic          rw_o,
   input  logic          rw_i
);

   initial begin
      assert (AW >= 2 && DW >= 2)
         else $error("xbus_ctrl: bus widths too small");
   end

   xbus_ph_e      phase;
   xbus_sel_t     sel;
   logic          cyc_we;
   logic [1:0]    cyc_space;
   logic [AW-1:0] cyc_addr;
   logic [DW-1:0] cyc_wdata;
   logic          in_cyc;
   logic          dma_act;
   logic          ram_drive;
   logic [DW-1:0] ram_data;

   xbus_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_n    (hold_n),
      .ready     (ready),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_space (req_space),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .data_i    (data_i),
      .phase     (phase),
      .req_ack   (req_ack),
      .cyc_we    (cyc_we),
      .cyc_space (cyc_space),
      .cyc_addr  (cyc_addr),
      .cyc_wdata (cyc_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign in_cyc  = (phase == PH_SETUP) || (phase == PH_STRB);
   assign dma_act = (phase == PH_HOLD) && !br_n;

   xbus_sel_dec u_sel (
      .active (in_cyc),
      .space  (cyc_space),
      .sel    (sel)
   );

   xbus_dma_ram #(.AW(AW), .DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .dma_act  (dma_act),
      .addr_i   (addr_i),
      .data_i   (data_i),
      .strb_i   (strb_i),
      .rw_i     (rw_i),
      .rd_drive (ram_drive),
      .rd_data  (ram_data)
   );

   assign holda_n = (phase != PH_HOLD);
   assign pin_oe  = off_n && (phase != PH_HOLD);
   assign addr_o  = cyc_addr;
   assign ds_n    = sel.ds_n;
   assign ps_n    = sel.ps_n;
   assign is_n    = sel.is_n;
   assign strb_o  = (phase != PH_STRB);
   assign rd_n    = !(in_cyc && !cyc_we);
   assign rw_o    = !(in_cyc && cyc_we);
   assign data_oe = rst_n && off_n && ((hold_n && in_cyc && cyc_we) || ram_drive);
   assign data_o  = ram_drive ? ram_data : cyc_wdata;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic off_n,
   input logic hold_n,
   input logic ready,
   input logic holda_n,
   input logic pin_oe,
   input logic data_oe,
   input logic ds_n,
   input logic ps_n,
   input logic is_n,
   input logic strb_o,
   input logic rd_n,
   input logic rw_o,
   input logic rsp_valid
);

   p_one_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_o |-> $countones({ds_n, ps_n, is_n}) == 2);

   p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_o && !ready) |=> !strb_o);

   p_write_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_o |-> ({ds_n, ps_n, is_n} != 3'b111));

   p_read_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (rw_o && {ds_n, ps_n, is_n} != 3'b111));

   p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!strb_o && ready && rw_o));

   p_off_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !off_n |-> (!pin_oe && !data_oe));

   p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !holda_n |-> (!pin_oe && strb_o));

   p_holda_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(holda_n) |-> !$past(hold_n));

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .off_n     (off_n),
   .hold_n    (hold_n),
   .ready     (ready),
   .holda_n   (holda_n),
   .pin_oe    (pin_oe),
   .data_oe   (data_oe),
   .ds_n      (ds_n),
   .ps_n      (ps_n),
   .is_n      (is_n),
   .strb_o    (strb_o),
   .rd_n      (rd_n),
   .rw_o      (rw_o),
   .rsp_valid (rsp_valid)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n, off_n, hold_n, br_n, ready;
   logic        req_valid, req_we;
   logic [1:0]  req_space;
   logic [15:0] req_addr, req_wdata;
   logic        req_ack, rsp_valid;
   logic [15:0] rsp_rdata;
   logic        holda_n, pin_oe, data_oe;
   logic [15:0] addr_o, addr_i, data_o, data_i;
   logic        ds_n, ps_n, is_n, strb_o, strb_i, rd_n, rw_o, rw_i;

   always #2 clk = ~clk;

   xbus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .off_n(off_n), .hold_n(hold_n), .br_n(br_n),
      .ready(ready), .req_valid(req_valid), .req_we(req_we),
      .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .holda_n(holda_n), .pin_oe(pin_oe), .addr_o(addr_o), .addr_i(addr_i),
      .data_oe(data_oe), .data_o(data_o), .data_i(data_i),
      .ds_n(ds_n), .ps_n(ps_n), .is_n(is_n), .strb_o(strb_o), .strb_i(strb_i),
      .rd_n(rd_n), .rw_o(rw_o), .rw_i(rw_i)
   );

   int vecs = 0;
   int fails = 0;
   bit done = 0;

   // behavioural reference: phase 0 idle, 1 setup, 2 strobe, 3 hold
   int          mph = 0;
   bit          m_we, m_rv, sprev = 1, lw = 1;
   int          m_sp, la;
   logic [15:0] m_addr, m_wd, m_rd, ld;
   logic [15:0] mem [int];

   task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check();
      bit cyc, wr_drv, dma_rd;
      logic [2:0] esel;
      cyc = (mph == 1 || mph == 2);
      esel = 3'b111;
      if (cyc) esel = (m_sp == 0) ? 3'b011 : (m_sp == 1) ? 3'b101 : 3'b110;
      cmp("R1 selects", {13'b0, ds_n, ps_n, is_n}, {13'b0, esel});
      if (cyc && off_n) cmp("R1 addr_o", addr_o, m_addr);
      cmp("R2 req_ack", {15'b0, req_ack}, {15'b0, rst_n && mph == 0 && hold_n && req_valid});
      cmp("R2 strb_o", {15'b0, strb_o}, {15'b0, mph != 2});
      cmp("R3 rw_o", {15'b0, rw_o}, {15'b0, !(cyc && m_we)});
      cmp("R4 rd_n", {15'b0, rd_n}, {15'b0, !(cyc && !m_we)});
      cmp("R5 rsp_valid", {15'b0, rsp_valid}, {15'b0, m_rv});
      if (m_rv) cmp("R5 rsp_rdata", rsp_rdata, m_rd);
      cmp("R6 pin_oe", {15'b0, pin_oe}, {15'b0, off_n && mph != 3});
      cmp("R8 holda_n", {15'b0, holda_n}, {15'b0, mph != 3});
      wr_drv = rst_n && off_n && hold_n && cyc && m_we;
      dma_rd = rst_n && off_n && mph == 3 && !br_n && !strb_i && rw_i && addr_i < 16'h0100;
      cmp("R7 data_oe", {15'b0, data_oe}, {15'b0, wr_drv || dma_rd});
      if (wr_drv) cmp("R7 data_o", data_o, m_wd);
      else if (dma_rd && mem.exists(int'(addr_i))) cmp("R10 data_o", data_o, mem[int'(addr_i)]);
   endtask

   task automatic model();
      bit nrv = 0;
      if (!rst_n) begin
         mph = 0; m_rv = 0; sprev = 1; lw = 1;
         return;
      end
      case (mph)
         0: if (!hold_n) mph = 3;
            else if (req_valid) begin
               m_we = req_we; m_sp = int'(req_space);
               m_addr = req_addr; m_wd = req_wdata; mph = 1;
            end
         1: mph = 2;
         2: if (ready) begin
               if (!m_we) begin nrv = 1; m_rd = data_i; end
               mph = hold_n ? 0 : 3;
            end
         default: begin
            if (!br_n) begin
               if (!strb_i) begin la = int'(addr_i); ld = data_i; lw = rw_i; end
               else if (!sprev && !lw && la < 256) mem[la] = ld;   // R9 window
            end
            if (hold_n) mph = 0;
         end
      endcase
      m_rv = nrv;
      sprev = strb_i;
   endtask

   task automatic step();
      #1 check();
      @(posedge clk);
      model();
      @(negedge clk);
   endtask

   task automatic core_acc(input bit we, input int sp, input logic [15:0] a,
                           input logic [15:0] d, input int waits);
      req_valid = 1; req_we = we; req_space = sp[1:0]; req_addr = a; req_wdata = d;
      ready = 0; step();
      req_valid = 0; step();
      for (int i = 0; i < waits; i++) step();
      ready = 1; data_i = d ^ 16'h5A5A; step();
      ready = 0; step();
   endtask

   task automatic dma_wr(input logic [15:0] a, input logic [15:0] d);
      addr_i = a; data_i = d; rw_i = 0; strb_i = 0; step();
      strb_i = 1; step();
      rw_i = 1;
   endtask

   task automatic dma_rd(input logic [15:0] a);
      addr_i = a; data_i = 16'h0; rw_i = 1; strb_i = 0; step();
      strb_i = 1; step();
   endtask

   initial begin
      rst_n = 0; off_n = 1; hold_n = 1; br_n = 1; ready = 0;
      req_valid = 0; req_we = 0; req_space = 0; req_addr = 0; req_wdata = 0;
      addr_i = 0; data_i = 0; strb_i = 1; rw_i = 1;
      @(negedge clk);
      repeat (3) step();                     // reset state
      rst_n = 1; step();
      core_acc(1, 0, 16'h1234, 16'hBEEF, 0);  // R1 R3 data write
      core_acc(0, 1, 16'h00F0, 16'h0F00, 2);  // R2 R4 R5 program read, 2 waits
      core_acc(0, 2, 16'hFFFF, 16'h1357, 0);  // R4 I/O read
      core_acc(1, 3, 16'h8001, 16'h0F0F, 1);  // R1 code 3 selects I/O
      core_acc(0, 0, 16'h0004, 16'hA0A0, 5);  // R2 long stretch
      off_n = 0;
      core_acc(1, 0, 16'h0042, 16'hA5A5, 1);  // R6 everything released
      off_n = 1;
      hold_n = 0; step(); step();            // R8 grant from idle
      br_n = 0;
      dma_wr(16'h0010, 16'h1111);            // R9
      dma_wr(16'h00FF, 16'h2222);
      dma_rd(16'h0010);                      // R10
      dma_rd(16'h00FF);
      dma_wr(16'h0110, 16'h3333);            // R9 outside window, ignored
      dma_rd(16'h0010);                      // alias word unchanged
      dma_rd(16'h0110);                      // R10 no drive outside window
      req_valid = 1; req_we = 0; req_space = 2; req_addr = 16'h0055;
      step(); step();                        // R8 not accepted while held
      br_n = 1; hold_n = 1; step();          // release
      ready = 0; step();                     // accepted now
      req_valid = 0; step();
      ready = 1; data_i = 16'h7777; step();
      ready = 0; step();
      req_valid = 1; req_we = 1; req_space = 1; req_addr = 16'h0200; req_wdata = 16'hC3C3;
      step();
      req_valid = 0; step();
      hold_n = 0; step(); step();            // R7 R8 hold during stretched write
      ready = 1; step();
      ready = 0; step(); step();
      hold_n = 1; step(); step();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

endmodule